// File: doc/BRIEF.md
# I2C Master Status Word and Interrupt Request

This block assembles the 16-bit read-only status word of an I2C master controller and reduces it to one level-sensitive interrupt request. It watches the SCL and SDA wires through two-flop synchronizers to find START and STOP conditions. A two-state machine records whether the bus is held: `BUS_FREE` moves to `BUS_HELD` on START, and `BUS_HELD` returns to `BUS_FREE` on STOP. Every other combination keeps the current state.

The serial engine reports its events as single-cycle pulses: transfer done, address not acknowledged, data not acknowledged, arbitration lost and start of a new transaction. It also drives an active level. The FIFOs supply their fill indications and a write strobe. The flag bits are sticky until a new transaction starts. The transfer-complete bit is cleared only by an explicit clear strobe. Software reads the word through a register decode that lies outside this block. The interrupt output is the OR of each enabled source.

Top module: `i2c_mstat_top`

## Requirements
- R1: After reset the status word reads 0x0000, and bits 15..11 read zero at all times.
- R2: Bit 10 (bus held) becomes 1 three clock edges after SDA falls while SCL is high (START). It becomes 0 three edges after SDA rises while SCL is high (STOP). A change on SDA while SCL is low has no effect on it.
- R3: Bit 9 (receive overflow) is 1 from the edge after a receive write while the receive FIFO is full. It clears on the edge after a transaction-start pulse. If both arrive in the same cycle, the overflow sets.
- R4: Bit 8 (transfer complete) sets on the edge after a done pulse. It holds until the edge after a clear strobe. If done and clear arrive together, the bit sets.
- R5: Bit 4 (address NACK) and bit 7 (data NACK) are set independently by their own pulses. Each clears on the edge after a transaction-start pulse.
- R6: Bit 5 (arbitration lost) sets on the edge after its pulse and clears on transaction start. Bit 6 (master busy) follows the engine's active level one edge later, and reads 0 while bit 5 is 1.
- R7: Bit 3 (receive request) equals the inverse of the receive-empty input, one edge later.
- R8: Bit 2 (transmit request) is 1 one edge after the transmit level is 0 or 1 while the address-with-write flag is 1. Otherwise it is 0.
- R9: Bits 1..0 encode the transmit FIFO level one edge later: 00 when empty, 11 when the level equals TX_DEPTH, and 01 for any level in between.
- R10: The interrupt is a combinational OR of the following terms: bit 8 with the done enable, bit 4 or bit 7 with the NACK enable, bit 5 with the arbitration enable, bit 3 with the receive enable, and bit 2 with the transmit enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | SCL wire level (asynchronous) |
| sda_in | input | 1 | SDA wire level (asynchronous) |
| eng_done | input | 1 | Transfer-complete pulse |
| eng_addr_nack | input | 1 | Address not acknowledged pulse |
| eng_data_nack | input | 1 | Data not acknowledged pulse |
| eng_arb_lost | input | 1 | Arbitration lost pulse |
| eng_active | input | 1 | Engine processing a transaction |
| eng_txn_start | input | 1 | New transaction start pulse |
| tx_level | input | TXLW (2) | Transmit FIFO entry count |
| tx_addr_wr_sent | input | 1 | Address with write direction has been sent |
| rx_push | input | 1 | Byte written into receive FIFO |
| rx_full | input | 1 | Receive FIFO full |
| rx_empty | input | 1 | Receive FIFO empty |
| done_clr | input | 1 | Clear strobe for transfer complete |
| en_done | input | 1 | Done interrupt enable |
| en_nack | input | 1 | NACK interrupt enable |
| en_arb | input | 1 | Arbitration interrupt enable |
| en_rx | input | 1 | Receive interrupt enable |
| en_tx | input | 1 | Transmit interrupt enable |
| status_word | output | 16 | Status word |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions check several rules on every cycle. START always leads to the held state and STOP to the free state. The done bit holds until it is cleared. An overflowing write always sets its flag. Master busy is low once arbitration is lost. A full transmit FIFO encodes as 11, and the interrupt never rises with all enables low. The bench scenarios cover what needs context. They measure the three-edge synchronizer latency and show that SDA toggles with SCL low are ignored. They also cover simultaneous set/clear priority and the full sweep of transmit level against the address-with-write flag. Finally, they sweep all 32 enable masks against two different flag patterns.

// File: rtl/mstat_pkg.sv
package mstat_pkg;

    localparam int STATUS_W = 16;

    // bit positions inside the status word
    localparam int B_BUS_HELD = 10;
    localparam int B_RX_OVF   = 9;
    localparam int B_DONE     = 8;
    localparam int B_DNACK    = 7;
    localparam int B_MBUSY    = 6;
    localparam int B_ARB      = 5;
    localparam int B_ANACK    = 4;
    localparam int B_RXREQ    = 3;
    localparam int B_TXREQ    = 2;

    typedef enum logic {
        BUS_FREE = 1'b0,
        BUS_HELD = 1'b1
    } bus_state_e;

    typedef struct packed {
        logic rx_ovf;
        logic done;
        logic dnack;
        logic mbusy;
        logic arb;
        logic anack;
    } evt_flags_t;

endpackage

// File: rtl/mstat_bus_monitor.sv
module mstat_bus_monitor
    import mstat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic bus_held
);

    localparam int SYNC_N = 2;

    logic [SYNC_N-1:0] scl_sync;
    logic [SYNC_N-1:0] sda_sync;
    logic              sda_prev;
    logic              start_det;
    logic              stop_det;
    bus_state_e        state_q;
    bus_state_e        state_d;

    // synchronizers idle high, matching a released bus
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sync <= '1;
            sda_sync <= '1;
            sda_prev <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[SYNC_N-2:0], scl_in};
            sda_sync <= {sda_sync[SYNC_N-2:0], sda_in};
            sda_prev <= sda_sync[SYNC_N-1];
        end
    end

    assign start_det = scl_sync[SYNC_N-1] &  sda_prev & ~sda_sync[SYNC_N-1];
    assign stop_det  = scl_sync[SYNC_N-1] & ~sda_prev &  sda_sync[SYNC_N-1];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_FREE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_FREE: if (start_det) state_d = BUS_HELD;
            BUS_HELD: if (stop_det)  state_d = BUS_FREE;
            default:                 state_d = BUS_FREE;
        endcase
    end

    assign bus_held = (state_q == BUS_HELD);

    a_r2_start_holds: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state_q == BUS_HELD));

    a_r2_stop_frees: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state_q == BUS_FREE));

endmodule

// File: rtl/mstat_event_flags.sv
module mstat_event_flags
    import mstat_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       eng_done,
    input  logic       done_clr,
    input  logic       eng_addr_nack,
    input  logic       eng_data_nack,
    input  logic       eng_arb_lost,
    input  logic       eng_active,
    input  logic       eng_txn_start,
    input  logic       rx_push,
    input  logic       rx_full,
    output evt_flags_t flags
);

    logic ovf_q, done_q, dnack_q, anack_q, arb_q, active_q;
    logic ovf_evt;

    assign ovf_evt = rx_push & rx_full;

    // set wins over clear for every sticky flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_q    <= 1'b0;
            done_q   <= 1'b0;
            dnack_q  <= 1'b0;
            anack_q  <= 1'b0;
            arb_q    <= 1'b0;
            active_q <= 1'b0;
        end else begin
            ovf_q    <= ovf_evt       | (ovf_q   & ~eng_txn_start);
            dnack_q  <= eng_data_nack | (dnack_q & ~eng_txn_start);
            anack_q  <= eng_addr_nack | (anack_q & ~eng_txn_start);
            arb_q    <= eng_arb_lost  | (arb_q   & ~eng_txn_start);
            done_q   <= eng_done      | (done_q  & ~done_clr);
            active_q <= eng_active;
        end
    end

    always_comb begin
        flags.rx_ovf = ovf_q;
        flags.done   = done_q;
        flags.dnack  = dnack_q;
        flags.anack  = anack_q;
        flags.arb    = arb_q;
        flags.mbusy  = active_q & ~arb_q;
    end

    a_r3_ovf_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> flags.rx_ovf);

    a_r4_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (flags.done && !done_clr) |=> flags.done);

    a_r4_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (done_clr && !eng_done) |=> !flags.done);

    a_r6_arb_blocks_busy: assert property (@(posedge clk) disable iff (!rst_n)
        eng_arb_lost |=> !flags.mbusy);

endmodule

// File: rtl/mstat_fifo_status.sv
module mstat_fifo_status #(
    parameter int TX_DEPTH = 2,
    parameter int TXLW     = $clog2(TX_DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TXLW-1:0] tx_level,
    input  logic            tx_addr_wr_sent,
    input  logic            rx_empty,
    output logic            tx_req,
    output logic            rx_req,
    output logic [1:0]      tx_code
);

    localparam logic [TXLW-1:0] LVL_FULL = TXLW'(TX_DEPTH);
    localparam logic [TXLW-1:0] LVL_ONE  = TXLW'(1);

    logic [1:0] code_d;

    always_comb begin
        if (tx_level == '0)            code_d = 2'b00;
        else if (tx_level >= LVL_FULL) code_d = 2'b11;
        else                           code_d = 2'b01;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_req  <= 1'b0;
            rx_req  <= 1'b0;
            tx_code <= 2'b00;
        end else begin
            tx_req  <= (tx_level <= LVL_ONE) & tx_addr_wr_sent;
            rx_req  <= ~rx_empty;
            tx_code <= code_d;
        end
    end

    a_r9_full_code: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_level == LVL_FULL) |=> (tx_code == 2'b11));

    a_r8_no_req_without_addr: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_addr_wr_sent |=> !tx_req);

endmodule

// File: rtl/i2c_mstat_top.sv
module i2c_mstat_top
    import mstat_pkg::*;
#(
    parameter int TX_DEPTH = 2,
    parameter int TXLW     = $clog2(TX_DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_in,
    input  logic                sda_in,
    input  logic                eng_done,
    input  logic                eng_addr_nack,
    input  logic                eng_data_nack,
    input  logic                eng_arb_lost,
    input  logic                eng_active,
    input  logic                eng_txn_start,
    input  logic [TXLW-1:0]     tx_level,
    input  logic                tx_addr_wr_sent,
    input  logic                rx_push,
    input  logic                rx_full,
    input  logic                rx_empty,
    input  logic                done_clr,
    input  logic                en_done,
    input  logic                en_nack,
    input  logic                en_arb,
    input  logic                en_rx,
    input  logic                en_tx,
    output logic [STATUS_W-1:0] status_word,
    output logic                irq
);

    logic       bus_held;
    evt_flags_t flags;
    logic       tx_req, rx_req;
    logic [1:0] tx_code;

    mstat_bus_monitor u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .bus_held (bus_held)
    );

    mstat_event_flags u_flags (
        .clk           (clk),
        .rst_n         (rst_n),
        .eng_done      (eng_done),
        .done_clr      (done_clr),
        .eng_addr_nack (eng_addr_nack),
        .eng_data_nack (eng_data_nack),
        .eng_arb_lost  (eng_arb_lost),
        .eng_active    (eng_active),
        .eng_txn_start (eng_txn_start),
        .rx_push       (rx_push),
        .rx_full       (rx_full),
        .flags         (flags)
    );

    mstat_fifo_status #(.TX_DEPTH(TX_DEPTH), .TXLW(TXLW)) u_fifo (
        .clk             (clk),
        .rst_n           (rst_n),
        .tx_level        (tx_level),
        .tx_addr_wr_sent (tx_addr_wr_sent),
        .rx_empty        (rx_empty),
        .tx_req          (tx_req),
        .rx_req          (rx_req),
        .tx_code         (tx_code)
    );

    always_comb begin
        status_word             = '0;
        status_word[B_BUS_HELD] = bus_held;
        status_word[B_RX_OVF]   = flags.rx_ovf;
        status_word[B_DONE]     = flags.done;
        status_word[B_DNACK]    = flags.dnack;
        status_word[B_MBUSY]    = flags.mbusy;
        status_word[B_ARB]      = flags.arb;
        status_word[B_ANACK]    = flags.anack;
        status_word[B_RXREQ]    = rx_req;
        status_word[B_TXREQ]    = tx_req;
        status_word[1:0]        = tx_code;
    end

    assign irq = (en_done & flags.done)
               | (en_nack & (flags.anack | flags.dnack))
               | (en_arb  & flags.arb)
               | (en_rx   & rx_req)
               | (en_tx   & tx_req);

    a_r10_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (en_done | en_nack | en_arb | en_rx | en_tx));

    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[STATUS_W-1:11] == '0);

endmodule

// File: tb/i2c_mstat_top_tb.sv
module i2c_mstat_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int TX_DEPTH   = 2;
    localparam int TXLW       = $clog2(TX_DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_in = 1'b1, sda_in = 1'b1;
    logic eng_done = 0, eng_addr_nack = 0, eng_data_nack = 0, eng_arb_lost = 0;
    logic eng_active = 0, eng_txn_start = 0;
    logic [TXLW-1:0] tx_level = '0;
    logic tx_addr_wr_sent = 0, rx_push = 0, rx_full = 0, rx_empty = 1, done_clr = 0;
    logic en_done = 0, en_nack = 0, en_arb = 0, en_rx = 0, en_tx = 0;
    logic [15:0] status_word;
    logic irq;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_mstat_top #(.TX_DEPTH(TX_DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .eng_done(eng_done), .eng_addr_nack(eng_addr_nack),
        .eng_data_nack(eng_data_nack), .eng_arb_lost(eng_arb_lost),
        .eng_active(eng_active), .eng_txn_start(eng_txn_start),
        .tx_level(tx_level), .tx_addr_wr_sent(tx_addr_wr_sent),
        .rx_push(rx_push), .rx_full(rx_full), .rx_empty(rx_empty),
        .done_clr(done_clr), .en_done(en_done), .en_nack(en_nack),
        .en_arb(en_arb), .en_rx(en_rx), .en_tx(en_tx),
        .status_word(status_word), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_en(input logic [4:0] m);
        {en_tx, en_rx, en_arb, en_nack, en_done} = m;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        step(3);
        // R1: reset value
        chk("R1 reset word", status_word, 16'h0000);
        chk("R1 reset irq", irq, 0);
        rst_n = 1'b1;
        step(2);
        chk("R1 idle after reset", status_word, 16'h0000);

        // R2: START with latency of three edges
        sda_in = 0;
        step(2);
        chk("R2 busy not yet", status_word[10], 0);
        step(1);
        chk("R2 busy after START", status_word[10], 1);
        // R2: SDA toggling while SCL low is ignored
        scl_in = 0; step(4);
        sda_in = 1; step(4);
        sda_in = 0; step(4);
        scl_in = 1; step(4);
        chk("R2 busy kept with SCL low toggles", status_word[10], 1);
        // STOP
        sda_in = 1;
        step(3);
        chk("R2 free after STOP", status_word[10], 0);
        chk("R1 reserved zero", status_word[15:11], 0);

        // R3: overflow
        rx_push = 1; rx_full = 0; step(1);
        rx_push = 0;
        chk("R3 push not full", status_word[9], 0);
        rx_push = 1; rx_full = 1; step(1);
        rx_push = 0; rx_full = 0;
        chk("R3 overflow set", status_word[9], 1);
        step(2);
        chk("R3 overflow sticky", status_word[9], 1);
        eng_txn_start = 1; step(1); eng_txn_start = 0;
        chk("R3 overflow cleared", status_word[9], 0);
        rx_push = 1; rx_full = 1; eng_txn_start = 1; step(1);
        rx_push = 0; rx_full = 0; eng_txn_start = 0;
        chk("R3 set wins over start", status_word[9], 1);
        eng_txn_start = 1; step(1); eng_txn_start = 0;

        // R4: transfer complete
        eng_done = 1; step(1); eng_done = 0;
        chk("R4 done set", status_word[8], 1);
        eng_txn_start = 1; step(3); eng_txn_start = 0;
        chk("R4 done held", status_word[8], 1);
        done_clr = 1; step(1); done_clr = 0;
        chk("R4 done cleared", status_word[8], 0);
        eng_done = 1; done_clr = 1; step(1); eng_done = 0; done_clr = 0;
        chk("R4 set wins over clear", status_word[8], 1);
        done_clr = 1; step(1); done_clr = 0;

        // R5: separate NACK bits
        eng_addr_nack = 1; step(1); eng_addr_nack = 0;
        chk("R5 addr nack only", {status_word[7], status_word[4]}, 2'b01);
        eng_data_nack = 1; step(1); eng_data_nack = 0;
        chk("R5 both nacks", {status_word[7], status_word[4]}, 2'b11);
        eng_txn_start = 1; step(1); eng_txn_start = 0;
        chk("R5 nacks cleared", {status_word[7], status_word[4]}, 2'b00);
        eng_data_nack = 1; step(1); eng_data_nack = 0;
        chk("R5 data nack only", {status_word[7], status_word[4]}, 2'b10);
        eng_txn_start = 1; step(1); eng_txn_start = 0;

        // R6: master busy and arbitration
        eng_active = 1; step(1);
        chk("R6 master busy", {status_word[6], status_word[5]}, 2'b10);
        eng_arb_lost = 1; step(1); eng_arb_lost = 0;
        chk("R6 arb lost masks busy", {status_word[6], status_word[5]}, 2'b01);
        eng_txn_start = 1; step(1); eng_txn_start = 0;
        chk("R6 arb cleared busy back", {status_word[6], status_word[5]}, 2'b10);
        eng_active = 0; step(1);
        chk("R6 idle", status_word[6], 0);

        // R7: receive request
        rx_empty = 0; step(1);
        chk("R7 rx request set", status_word[3], 1);
        rx_empty = 1; step(1);
        chk("R7 rx request cleared", status_word[3], 0);

        // R8/R9: sweep transmit level against address flag
        for (int lvl = 0; lvl <= TX_DEPTH; lvl++) begin
            for (int aw = 0; aw < 2; aw++) begin
                logic [2:0] exp;
                tx_level = TXLW'(lvl);
                tx_addr_wr_sent = aw[0];
                step(1);
                exp[2]   = (lvl <= 1) && (aw == 1);
                exp[1:0] = (lvl == 0) ? 2'b00 : (lvl == TX_DEPTH) ? 2'b11 : 2'b01;
                chk("R8 R9 tx sweep", status_word[2:0], exp);
            end
        end

        // R10: enable sweep, pattern A: all sources active
        eng_done = 1; eng_addr_nack = 1; eng_arb_lost = 1; step(1);
        eng_done = 0; eng_addr_nack = 0; eng_arb_lost = 0;
        rx_empty = 0; tx_level = '0; tx_addr_wr_sent = 1; step(1);
        for (int m = 0; m < 32; m++) begin
            set_en(5'(m));
            #1;
            chk("R10 irq pattern A", irq, (m != 0));
        end
        // pattern B: only data NACK and receive request
        eng_txn_start = 1; done_clr = 1; tx_addr_wr_sent = 0; step(1);
        eng_txn_start = 0; done_clr = 0;
        eng_data_nack = 1; step(1); eng_data_nack = 0;
        for (int m = 0; m < 32; m++) begin
            set_en(5'(m));
            #1;
            chk("R10 irq pattern B", irq, (m[1] | m[3]));
        end
        set_en(5'd0);
        step(1);
        finish_run();
    end

endmodule